// File: doc/BRIEF.md
# Multi-Channel Angle Converter Register Front End

This block sits between a 16-bit word-wide I/O bus and a card that carries up to four tracking angle converters. It claims a 16-byte window of the I/O space at a base address fixed by a parameter. Inside that window it turns the low address bits into per-channel angle reads, one status read and one control write. The angle words keep changing as the converters track. The block gives the host a coherent snapshot of each word, so the host never has to halt a converter before it reads.

Each converter raises a busy flag while its word is being updated. A read of a channel samples that converter's word on the first cycle, counting from the read strobe, in which its busy flag is low. The block retries for a bounded number of cycles. If the flag never drops, it returns the last word that the channel presented while not busy. The status word carries the active-low health flag of each channel. The control word selects normal tracking or one of three forced test angles, and drives those two select lines straight to the converters. After a mode change the host polls the status word until the converters report healthy again.

The register map follows the channel count: the angle registers come first, then status, then control. A 3-channel build and a 4-channel build therefore place status and control at different offsets.

Top module: `abf_front`

## Requirements
- R1: An access is in the window when address bits 15..4 equal bits 15..4 of `BASE_ADDR` (default 0300h). A read outside the window never raises `bus_rd_oe`. A write outside the window leaves `test_sel` unchanged.
- R2: For an even in-window offset 2*i: i < NUM_CH selects the angle word of channel i, i = NUM_CH selects status and i = NUM_CH+1 selects control. With 4 channels these are angles at 00h..06h, status at 08h and control at 0Ah. With 3 channels they are angles at 00h..04h, status at 06h and control at 08h.
- R3: An angle read returns the converter word left-justified in 16 bits: word << (16 - ANGLE_W), with the low bits zero.
- R4: A read strobe sampled on edge E0 is answered after the first edge Ek, k in 0..RETRY_MAX (default 4), at which the addressed channel's busy flag is low. `bus_rd_oe` is high for the cycle after Ek, and the data is the word present at Ek.
- R5: If the busy flag is high at E0 and at all RETRY_MAX following edges, the answer comes after edge E(RETRY_MAX). It carries the last word the channel presented while not busy, or 0 if there has been none since reset.
- R6: A status read is answered after E0. Bit i (i < 4) is the health flag of channel i: 1 means healthy and 0 means fault. Bits for absent channels read 1. Bits 15..4 read 0.
- R7: A write to the control offset sets `test_sel` to wdata[1:0] after the write edge. The encoding is 00 run, 01 force 90 degrees, 10 force 0 degrees and 11 force 30 degrees. Bits 15..2 of the write data are ignored.
- R8: A reset, synchronous and active low, sets `test_sel` to 00 and `bus_rd_oe` low.
- R9: Reads of an odd in-window address, of an offset above the map, or of the control offset are answered after E0 with 0000h. Writes to any in-window offset other than control leave `test_sel` unchanged.
- R10: `bus_rdata` is 0000h whenever `bus_rd_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (16) | I/O address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, valid with `bus_rd_oe` |
| bus_rd_oe | output | 1 | Read answer and data-bus drive enable, one cycle |
| cnv_angle | input | NUM_CH*ANGLE_W | Live angle words, channel 0 in the low bits |
| cnv_busy | input | NUM_CH | Per-channel update-in-progress flag |
| cnv_good | input | NUM_CH | Per-channel health flag, 0 = fault |
| test_sel | output | 2 | Test-angle select to the converters |

## Verification
The bench drives converters whose words change every clock. Each channel cycles through busy patterns: never busy, busy on alternate cycles, busy on all but one cycle in sixteen, and busy for six cycles in eight. Reads therefore hit immediate capture, capture on the last retry, and the fallback word, and a design that sampled a word while its busy flag was high would return the bit-inverted garbage the bench drives then. A 3-channel and a 4-channel instance are swept over all sixteen offsets for both reads and writes. A design with a fixed map would misplace status and control on one of the two builds, and one that decoded upper data bits or odd addresses would corrupt the test select. Reads outside the window and a reset in the middle of the run check that the bus stays undriven and that the control register returns to run mode.

// File: rtl/abf_pkg.sv
// Shared types for the angle converter bus front end.
package abf_pkg;

    // Which register an address points at.
    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_ANGLE  = 2'd1,
        REG_STATUS = 2'd2,
        REG_CTRL   = 2'd3
    } reg_kind_e;

    // Test-angle selection driven to the converters; the encoding is seen by them.
    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_DEG90 = 2'b01,
        MODE_DEG0  = 2'b10,
        MODE_DEG30 = 2'b11
    } test_mode_e;

    // Width of the register index taken from address bits 3..1.
    localparam int REG_SEL_W = 3;

endpackage

// File: rtl/abf_addr_decode.sv
// Address decoder.
// Compares the upper address bits with the window base and classifies the
// word offset. The map depends on NUM_CH: angles first, then status, then
// control. Odd addresses classify as REG_NONE.
// Assumes NUM_CH + 1 < 2**REG_SEL_W.
module abf_addr_decode
    import abf_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              NUM_CH    = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h300,
    parameter int              CH_W      = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   ch_idx
);
    localparam int WIN_LSB = REG_SEL_W + 1;

    logic [REG_SEL_W-1:0] reg_idx;

    assign hit     = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
    assign reg_idx = addr[REG_SEL_W:1];
    assign ch_idx  = reg_idx[CH_W-1:0];

    // Classify the word offset against the channel-count-dependent map.
    always_comb begin
        if (addr[0]) begin
            kind = REG_NONE;
        end else if (reg_idx < REG_SEL_W'(NUM_CH)) begin
            kind = REG_ANGLE;
        end else if (reg_idx == REG_SEL_W'(NUM_CH)) begin
            kind = REG_STATUS;
        end else if (reg_idx == REG_SEL_W'(NUM_CH + 1)) begin
            kind = REG_CTRL;
        end else begin
            kind = REG_NONE;
        end
    end

endmodule

// File: rtl/abf_snapshot.sv
// Coherent angle capture.
// On start, samples the addressed channel's live word in the first cycle
// in which its busy flag is low, waiting up to RETRY_MAX further cycles.
// If the flag never drops, it returns the channel's last word seen while not
// busy. done and word are combinational so that the caller's output register
// adds exactly one cycle.
// Assumes start is only raised while idle is high and start_ch < NUM_CH.
module abf_snapshot #(
    parameter int NUM_CH    = 4,
    parameter int ANGLE_W   = 14,
    parameter int RETRY_MAX = 4,
    parameter int CH_W      = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CH_W-1:0]           start_ch,
    input  logic [NUM_CH*ANGLE_W-1:0] cnv_angle,
    input  logic [NUM_CH-1:0]         cnv_busy,
    output logic                      idle,
    output logic                      done,
    output logic [ANGLE_W-1:0]        word
);
    localparam int CNT_W = (RETRY_MAX > 1) ? $clog2(RETRY_MAX) : 1;

    logic [ANGLE_W-1:0] live_arr  [NUM_CH];
    logic [ANGLE_W-1:0] last_good [NUM_CH];

    logic              waiting;
    logic [CH_W-1:0]   wait_ch;
    logic [CNT_W-1:0]  wait_cnt;
    logic [CH_W-1:0]   sel_ch;
    logic              busy_now;
    logic              expired;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign live_arr[g] = cnv_angle[g*ANGLE_W +: ANGLE_W];

        // Keep the most recent complete word of this channel as the fallback.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                last_good[g] <= '0;
            end else if (!cnv_busy[g]) begin
                last_good[g] <= live_arr[g];
            end
        end
    end

    assign sel_ch   = waiting ? wait_ch : start_ch;
    assign busy_now = cnv_busy[sel_ch];
    assign expired  = waiting && (wait_cnt == CNT_W'(RETRY_MAX - 1));
    assign done     = (start || waiting) && (!busy_now || expired);
    assign word     = busy_now ? last_good[sel_ch] : live_arr[sel_ch];
    assign idle     = !waiting;

    // Track a read that is waiting for its channel to leave the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting  <= 1'b0;
            wait_ch  <= '0;
            wait_cnt <= '0;
        end else if (start && busy_now) begin
            waiting  <= 1'b1;
            wait_ch  <= start_ch;
            wait_cnt <= '0;
        end else if (waiting) begin
            if (done) begin
                waiting <= 1'b0;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/abf_test_ctrl.sv
// Test-angle control register.
// Holds the two-bit test select; reset returns it to normal run.
module abf_test_ctrl
    import abf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output test_mode_e mode
);
    // Load a new test-angle selection on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RUN;
        end else if (wr_en) begin
            mode <= test_mode_e'(wr_code);
        end
    end

endmodule

// File: rtl/abf_front.sv
// Top of the angle converter bus front end.
// Decodes the I/O window, answers status and undefined reads at once and
// angle reads through the coherent capture unit, and keeps the test select.
// Every read answer is registered: bus_rd_oe pulses for one cycle with data.
// Assumes one read is in flight at a time; strobes arriving while a capture
// waits are dropped.
module abf_front
    import abf_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                NUM_CH    = 4,
    parameter int                ANGLE_W   = 14,
    parameter int                RETRY_MAX = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h300
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd,
    input  logic                      bus_wr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_rd_oe,
    input  logic [NUM_CH*ANGLE_W-1:0] cnv_angle,
    input  logic [NUM_CH-1:0]         cnv_busy,
    input  logic [NUM_CH-1:0]         cnv_good,
    output logic [1:0]                test_sel
);
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SHIFT   = DATA_W - ANGLE_W;
    localparam int STAT_W  = 4;

    logic               hit;
    reg_kind_e          kind;
    logic [CH_W-1:0]    ch_idx;
    logic               snap_idle;
    logic               snap_done;
    logic               snap_start;
    logic [ANGLE_W-1:0] snap_word;
    logic               imm_rd;
    logic               ctrl_wr;
    logic [STAT_W-1:0]  status_nib;
    logic [DATA_W-1:0]  imm_word;
    test_mode_e         mode;
    logic               unused_wdata_hi;

    abf_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_CH    (NUM_CH),
        .BASE_ADDR (BASE_ADDR),
        .CH_W      (CH_W)
    ) u_decode (
        .addr   (bus_addr),
        .hit    (hit),
        .kind   (kind),
        .ch_idx (ch_idx)
    );

    assign snap_start = bus_rd && hit && snap_idle && (kind == REG_ANGLE);
    assign imm_rd     = bus_rd && hit && snap_idle && (kind != REG_ANGLE);
    assign ctrl_wr    = bus_wr && hit && (kind == REG_CTRL);

    abf_snapshot #(
        .NUM_CH    (NUM_CH),
        .ANGLE_W   (ANGLE_W),
        .RETRY_MAX (RETRY_MAX),
        .CH_W      (CH_W)
    ) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (snap_start),
        .start_ch  (ch_idx),
        .cnv_angle (cnv_angle),
        .cnv_busy  (cnv_busy),
        .idle      (snap_idle),
        .done      (snap_done),
        .word      (snap_word)
    );

    abf_test_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr),
        .wr_code (bus_wdata[1:0]),
        .mode    (mode)
    );

    assign test_sel        = mode;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:2];

    // Health flags per status bit; bits of absent channels report healthy.
    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        if (i < NUM_CH) begin : g_live
            assign status_nib[i] = cnv_good[i];
        end else begin : g_absent
            assign status_nib[i] = 1'b1;
        end
    end

    assign imm_word = (kind == REG_STATUS) ? DATA_W'(status_nib) : '0;

    // Register the read answer and its one-cycle drive enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rd_oe <= 1'b0;
            bus_rdata <= '0;
        end else if (snap_done) begin
            bus_rd_oe <= 1'b1;
            bus_rdata <= DATA_W'(snap_word) << SHIFT;
        end else if (imm_rd) begin
            bus_rd_oe <= 1'b1;
            bus_rdata <= imm_word;
        end else begin
            bus_rd_oe <= 1'b0;
            bus_rdata <= '0;
        end
    end

endmodule

// File: rtl/abf_front_chk.sv
// Assertion checker for abf_front, attached by bind below.
// Uses the ports plus the capture unit's idle flag.
module abf_front_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter int                NUM_CH    = 4,
    parameter int                ANGLE_W   = 14,
    parameter int                RETRY_MAX = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h300
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_rd,
    input logic                      bus_wr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic                      bus_rd_oe,
    input logic [NUM_CH*ANGLE_W-1:0] cnv_angle,
    input logic [NUM_CH-1:0]         cnv_busy,
    input logic [NUM_CH-1:0]         cnv_good,
    input logic [1:0]                test_sel,
    input logic                      snap_idle
);
    localparam int SHIFT = DATA_W - ANGLE_W;

    logic              in_win;
    logic              is_angle;
    logic              busy_at;
    logic [DATA_W-1:0] live_at;
    logic [3:0]        exp_nib;
    logic [7:0]        wait_cycles;

    assign in_win   = (bus_addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
    assign is_angle = !bus_addr[0] && (bus_addr[3:1] < 3'(NUM_CH));

    // Busy flag and justified live word of the addressed channel.
    always_comb begin
        busy_at = 1'b0;
        live_at = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr[3:1] == 3'(c)) begin
                busy_at = cnv_busy[c];
                live_at = DATA_W'(cnv_angle[c*ANGLE_W +: ANGLE_W]) << SHIFT;
            end
        end
    end

    // Expected status nibble from the health inputs.
    always_comb begin
        exp_nib = 4'hF;
        for (int c = 0; c < NUM_CH && c < 4; c++) begin
            exp_nib[c] = cnv_good[c];
        end
    end

    // Count consecutive cycles in which a capture is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n || snap_idle) begin
            wait_cycles <= '0;
        end else if (wait_cycles != 8'hFF) begin
            wait_cycles <= wait_cycles + 1'b1;
        end
    end

    // R1
    outside_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !in_win) |=> $stable(test_sel));

    // R4
    ready_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && snap_idle && in_win && is_angle && !busy_at)
        |=> (bus_rd_oe && bus_rdata == $past(live_at)));

    // R5
    bounded_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_idle |-> (wait_cycles < 8'(RETRY_MAX)));

    // R6
    status_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && snap_idle && in_win && !bus_addr[0] && bus_addr[3:1] == 3'(NUM_CH))
        |=> (bus_rd_oe && bus_rdata == DATA_W'($past(exp_nib))));

    // R7
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && in_win && !bus_addr[0] && bus_addr[3:1] == 3'(NUM_CH + 1))
        |=> (test_sel == $past(bus_wdata[1:0])));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (test_sel == 2'b00 && !bus_rd_oe));

    // R9
    odd_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && snap_idle && in_win && bus_addr[0])
        |=> (bus_rd_oe && bus_rdata == '0));

    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_oe |-> (bus_rdata == '0));

endmodule

bind abf_front abf_front_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_CH    (NUM_CH),
    .ANGLE_W   (ANGLE_W),
    .RETRY_MAX (RETRY_MAX),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_rd_oe (bus_rd_oe),
    .cnv_angle (cnv_angle),
    .cnv_busy  (cnv_busy),
    .cnv_good  (cnv_good),
    .test_sel  (test_sel),
    .snap_idle (snap_idle)
);

// File: tb/abf_front_bench.sv
// Bench: a 4-channel and a 3-channel instance share one bus and one set of
// converter models whose words change every clock.
module abf_front_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [4*AW-1:0] cnv_angle = '0;
    logic [3:0]  cnv_busy = '0;
    logic [3:0]  cnv_good = 4'hF;

    logic [15:0] rdata4, rdata3;
    logic        oe4, oe3;
    logic [1:0]  sel4, sel3;

    int tick = 0;
    int total = 0;
    int fails = 0;
    logic [1:0] exp_sel4 = 2'b00;
    logic [1:0] exp_sel3 = 2'b00;

    abf_front #(.NUM_CH(4), .ANGLE_W(AW)) u_abf_front (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata4),
        .bus_rd_oe(oe4), .cnv_angle(cnv_angle), .cnv_busy(cnv_busy),
        .cnv_good(cnv_good), .test_sel(sel4)
    );

    abf_front #(.NUM_CH(3), .ANGLE_W(AW)) u_abf_front_3ch (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata3),
        .bus_rd_oe(oe3), .cnv_angle(cnv_angle[3*AW-1:0]), .cnv_busy(cnv_busy[2:0]),
        .cnv_good(cnv_good[2:0]), .test_sel(sel3)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Complete word of channel c at tick t.
    function automatic logic [AW-1:0] good_word(int c, int t);
        return AW'(t * 37 + c * 1021 + 5);
    endfunction

    // Busy pattern: class rotates every 16 ticks, offset per channel.
    function automatic bit busy_f(int c, int t);
        int cls;
        cls = ((t >> 4) + c) & 3;
        case (cls)
            0: return 1'b0;
            1: return t[0];
            2: return (t % 16) != 0;
            default: return (t % 8) < 6;
        endcase
    endfunction

    // Converter models: new tick each falling edge; garbage while busy.
    always @(negedge clk) begin
        tick = tick + 1;
        for (int c = 0; c < 4; c++) begin
            cnv_busy[c] = busy_f(c, tick);
            cnv_angle[c*AW +: AW] = busy_f(c, tick) ? ~good_word(c, tick) : good_word(c, tick);
        end
    end

    task automatic chk(input bit ok, input string tag, input string what);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Expected answer of an nch-channel build to a read of a sampled at tick t0.
    task automatic model_read(input int nch, input logic [15:0] a, input int t0,
                              output bit drv, output int lat, output logic [15:0] val,
                              output string tag);
        int idx;
        bit found;
        drv = (a[15:4] == 12'h030);
        lat = 0;
        val = '0;
        tag = "R1";
        if (!drv) return;
        idx = int'(a[3:1]);
        if (a[0]) begin
            tag = "R9";
        end else if (idx < nch) begin
            found = 1'b0;
            for (int k = 0; k <= 4; k++) begin
                if (!found && !busy_f(idx, t0 + k)) begin
                    found = 1'b1;
                    lat = k;
                    val = 16'(good_word(idx, t0 + k)) << (16 - AW);
                end
            end
            if (found) begin
                tag = "R2 R3 R4";
            end else begin
                tag = "R2 R3 R5";
                lat = 4;
                for (int k = 40; k >= 1; k--) begin
                    if (!busy_f(idx, t0 - k)) val = 16'(good_word(idx, t0 - k)) << (16 - AW);
                end
            end
        end else if (idx == nch) begin
            tag = "R2 R6";
            for (int b = 0; b < 4; b++) val[b] = (b < nch) ? cnv_good[b] : 1'b1;
        end else begin
            tag = "R9";
        end
    endtask

    task automatic judge(input string dut, input int nch, input logic [15:0] a, input int t0,
                         input int got_k, input logic [15:0] got_d, input bit noisy);
        bit drv; int lat; logic [15:0] val; string tag;
        model_read(nch, a, t0, drv, lat, val, tag);
        if (!drv) begin
            chk(got_k < 0, tag, $sformatf("%s addr=%h act lat=%0d exp no answer", dut, a, got_k));
        end else begin
            chk(got_k == lat && got_d == val, tag,
                $sformatf("%s addr=%h t0=%0d act lat=%0d data=%h exp lat=%0d data=%h",
                          dut, a, t0, got_k, got_d, lat, val));
        end
        chk(!noisy, "R10", $sformatf("%s addr=%h act data!=0 with oe low exp 0000", dut, a));
    endtask

    task automatic do_read(input logic [15:0] a);
        int t0; int k4; int k3;
        logic [15:0] d4; logic [15:0] d3;
        bit z4; bit z3;
        k4 = -1; k3 = -1; d4 = '0; d3 = '0; z4 = 0; z3 = 0;
        @(negedge clk); #1;
        bus_addr = a; bus_rd = 1'b1; t0 = tick;
        @(negedge clk); #1;
        bus_rd = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (k > 0) begin
                @(negedge clk); #1;
            end
            if (oe4) begin
                if (k4 < 0) begin k4 = k; d4 = rdata4; end
            end else if (rdata4 != 0) z4 = 1;
            if (oe3) begin
                if (k3 < 0) begin k3 = k; d3 = rdata3; end
            end else if (rdata3 != 0) z3 = 1;
        end
        judge("4ch", 4, a, t0, k4, d4, z4);
        judge("3ch", 3, a, t0, k3, d3, z3);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d);
        string tag;
        @(negedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); #1;
        bus_wr = 1'b0;
        if (a[15:4] == 12'h030 && !a[0] && a[3:1] == 3'd5) exp_sel4 = d[1:0];
        if (a[15:4] == 12'h030 && !a[0] && a[3:1] == 3'd4) exp_sel3 = d[1:0];
        tag = (a[15:4] != 12'h030) ? "R1" : "R7 R9";
        chk(sel4 == exp_sel4, tag, $sformatf("4ch write %h<=%h act sel=%b exp %b", a, d, sel4, exp_sel4));
        chk(sel3 == exp_sel3, tag, $sformatf("3ch write %h<=%h act sel=%b exp %b", a, d, sel3, exp_sel3));
    endtask

    task automatic check_reset_state;
        chk(sel4 == 2'b00 && !oe4, "R8", $sformatf("4ch act sel=%b oe=%b exp 00/0", sel4, oe4));
        chk(sel3 == 2'b00 && !oe3, "R8", $sformatf("3ch act sel=%b oe=%b exp 00/0", sel3, oe3));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        fails++;
        $display("FAIL watchdog act running exp finished");
        finish_run();
    end

    initial begin
        logic [15:0] outside [8];
        outside = '{16'h0310, 16'h02F0, 16'h0000, 16'hFFFF,
                    16'h1300, 16'h0B02, 16'h0384, 16'h0700};
        repeat (5) @(negedge clk);
        #1;
        check_reset_state();
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        // Register map sweep under several health patterns (R2, R6, R9).
        for (int p = 0; p < 4; p++) begin
            cnv_good = (p == 0) ? 4'hF : (p == 1) ? 4'h0 : (p == 2) ? 4'h5 : 4'hA;
            for (int off = 0; off < 16; off++) do_read(16'h0300 | 16'(off));
        end
        cnv_good = 4'hF;

        // Angle capture under every busy class (R3, R4, R5).
        for (int i = 0; i < 200; i++) begin
            repeat (i % 4) @(negedge clk);
            do_read(16'h0300 + 16'((i % 4) * 2));
        end

        // Reads outside the window (R1).
        for (int i = 0; i < 8; i++) do_read(outside[i]);

        // Write sweep: every offset, every code, upper data bits set (R7, R9).
        for (int r = 0; r < 4; r++) begin
            for (int off = 0; off < 16; off++) begin
                do_write(16'h0300 | 16'(off), 16'hFFFC | 16'((off + r) & 3));
            end
        end
        do_write(16'h030A, 16'h0002);
        do_write(16'h0308, 16'h0001);
        for (int i = 0; i < 8; i++) do_write(outside[i], 16'h0003);

        // Reset in mid-run returns to run mode (R8).
        @(negedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check_reset_state();
        exp_sel4 = 2'b00;
        exp_sel3 = 2'b00;
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        for (int i = 0; i < 16; i++) do_read(16'h0300 + 16'((i % 4) * 2));

        finish_run();
    end

endmodule